// File: doc/BRIEF.md
# Raster-Scan 3x3 Window Buffer for Digit Codes

This block accepts a stream of 12-bit signed-digit codes, one per cycle when the input is valid, in raster-scan order from a frame whose row width is set at the start of each frame. It presents the 3x3 neighbourhood that ends at the most recent element. A downstream multiplier-free filter can then work on one full window per accepted element once the first two rows and the first two columns of the third row have arrived.

The two earlier rows are kept in a single RAM split into two row slots. The slot that a row uses alternates from one row to the next. Each new element is written at the address its column occupies in the current slot. The same column in both slots is read in that cycle, so no stored data is ever copied or moved. Only the nine window entries are held in flip-flops. Each accepted element shifts the window one column to the left and loads a fresh right-hand column. This keeps the window aligned without any extra alignment logic.

Top module: `rsw_tile_buf`

## Requirements
- R1: While reset is held and after it is released, `win_valid` is 0 and all nine window entries are 0 until elements are accepted.
- R2: An element accepted with `sof`=1 is row 0, column 0 of a new frame, and `row_len` is captured as that frame's width (legal range 3 to MAX_W). `row_len` is ignored on all other elements.
- R3: `win_valid` is 1 in the cycle after an accepted element exactly when that element's zero-based row is at least 2 and its column is at least 2. The first window of a frame of width W therefore follows its element number 2W+3. Columns 0 and 1 never produce a window, so no window spans a row boundary.
- R4: When `win_valid` is 1, entry e (bits [12e+11:12e] of `win`, e = 3r+k, with r and k each from 0 to 2) holds the code at frame row (row-2+r), column (col-2+k) relative to the last accepted element. Entry 8 is that element itself.
- R5: In a cycle with `in_valid`=0, the next cycle has `win_valid`=0 and an unchanged `win`, and the stream continues where it left off.
- R6: A `sof` element in the middle of a frame abandons that frame. No window is produced until row 2, column 2 of the new frame, and later windows contain only codes from the new frame, even when its width differs.
- R7: When two consecutive accepted elements both produce windows, the left and middle columns of the second window equal the middle and right columns of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_len | input | 11 | Frame width, sampled with `sof` |
| in_valid | input | 1 | An element is presented this cycle |
| sof | input | 1 | Marks the first element of a frame |
| in_code | input | 12 | Signed-digit code of the element |
| win_valid | output | 1 | `win` holds a complete window |
| win | output | 108 | Nine 12-bit entries, entry 3r+k at bits [12(3r+k)+11 : 12(3r+k)] |

## Verification
Every result is due one clock edge after the element that causes it. The bench drives each element after a falling edge and samples `win_valid` and `win` at the next falling edge. This is the point at which the single output register has taken that element into account. Idle cycles are checked on the same one-cycle rule: `win` must match the value sampled before the idle cycle. Expected codes come from a closed-form function of frame, row and column, so every window position in small frames of several widths is compared, including the frame that follows an aborted one.

// File: rtl/rsw_tile_buf.sv
module rsw_tile_buf #(
  parameter int CODE_W = 12,
  parameter int MAX_W  = 1024,
  localparam int CW = $clog2(MAX_W),
  localparam int LW = $clog2(MAX_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LW-1:0]         row_len,
  input  logic                  in_valid,
  input  logic                  sof,
  input  logic [CODE_W-1:0]     in_code,
  output logic                  win_valid,
  output logic [9*CODE_W-1:0]   win
);

  logic [CODE_W-1:0] line_mem [2*MAX_W];
  logic [CODE_W-1:0] tile [9];
  logic [LW-1:0] wid, eff_w;
  logic [CW-1:0] col, col_now;
  logic [1:0]    row, row_now;
  logic          slot, slot_now, row_end;
  logic [CODE_W-1:0] old_rd, mid_rd;

  assign col_now  = sof ? '0 : col;
  assign row_now  = sof ? 2'd0 : row;
  assign slot_now = sof ? 1'b0 : slot;
  assign eff_w    = sof ? row_len : wid;
  assign row_end  = (LW'(col_now) == eff_w - LW'(1));

  assign old_rd = line_mem[{slot_now, col_now}];
  assign mid_rd = line_mem[{~slot_now, col_now}];

  always_ff @(posedge clk)
    if (in_valid) line_mem[{slot_now, col_now}] <= in_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid       <= LW'(MAX_W);
      col       <= '0;
      row       <= 2'd0;
      slot      <= 1'b0;
      win_valid <= 1'b0;
      for (int i = 0; i < 9; i++) tile[i] <= '0;
    end else begin
      win_valid <= in_valid && (row_now == 2'd2) && (col_now >= CW'(2));
      if (in_valid) begin
        wid <= eff_w;
        if (row_end) begin
          col  <= '0;
          slot <= ~slot_now;
          row  <= (row_now == 2'd2) ? 2'd2 : row_now + 2'd1;
        end else begin
          col  <= col_now + CW'(1);
          slot <= slot_now;
          row  <= row_now;
        end
        for (int r = 0; r < 3; r++) begin
          tile[3*r]   <= tile[3*r+1];
          tile[3*r+1] <= tile[3*r+2];
        end
        tile[2] <= old_rd;
        tile[5] <= mid_rd;
        tile[8] <= in_code;
      end
    end
  end

  for (genvar e = 0; e < 9; e++) begin : g_out
    assign win[e*CODE_W +: CODE_W] = tile[e];
  end

  // R2: a frame width must fit the line storage
  a_r2_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sof) |-> (row_len >= LW'(3) && row_len <= LW'(MAX_W)));

  // R5: an idle cycle yields no window and freezes the tile
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!win_valid && $stable(win)));

  // R6: the first element of a frame never completes a window
  a_r6_sof_no_win: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sof) |=> !win_valid);

  // R3: a window is only ever reported for an accepted element
  a_r3_from_input: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> $past(in_valid));

  for (genvar r = 0; r < 3; r++) begin : g_chk
    // R7: back-to-back windows slide by one column
    a_r7_slide_left: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && $past(win_valid)) |->
        (win[(3*r)*CODE_W +: CODE_W] == $past(win[(3*r+1)*CODE_W +: CODE_W])));
    a_r7_slide_mid: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && $past(win_valid)) |->
        (win[(3*r+1)*CODE_W +: CODE_W] == $past(win[(3*r+2)*CODE_W +: CODE_W])));
  end

endmodule

// File: tb/sim_rsw_tile_buf.sv
module sim_rsw_tile_buf;
  localparam int CODE_W = 12;
  localparam int MAX_W  = 16;
  localparam int LW     = $clog2(MAX_W + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LW-1:0] row_len = '0;
  logic in_valid = 1'b0, sof = 1'b0;
  logic [CODE_W-1:0] in_code = '0;
  logic win_valid;
  logic [9*CODE_W-1:0] win;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rsw_tile_buf #(.CODE_W(CODE_W), .MAX_W(MAX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .row_len(row_len), .in_valid(in_valid),
    .sof(sof), .in_code(in_code), .win_valid(win_valid), .win(win));

  function automatic logic [CODE_W-1:0] code_of(int f, int r, int c);
    return CODE_W'(f * 389 + r * 37 + c * 11 + r * c * 3 + 5);
  endfunction

  task automatic send(int f, int r, int c, int w, string tag);
    row_len  = LW'(w);
    sof      = (r == 0 && c == 0);
    in_valid = 1'b1;
    in_code  = code_of(f, r, c);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    sof      = 1'b0;
    row_len  = LW'(1);
    checks++;
    if (win_valid !== (r >= 2 && c >= 2)) begin
      errors++;
      $display("FAIL R3/%s win_valid f%0d r%0d c%0d: got %0b exp %0b",
               tag, f, r, c, win_valid, (r >= 2 && c >= 2));
    end
    if (r >= 2 && c >= 2) begin
      checks++;
      for (int e = 0; e < 9; e++) begin
        logic [CODE_W-1:0] ex;
        ex = code_of(f, r - 2 + e / 3, c - 2 + e % 3);
        if (win[e*CODE_W +: CODE_W] !== ex) begin
          errors++;
          $display("FAIL R4/%s entry %0d f%0d r%0d c%0d: got %0h exp %0h",
                   tag, e, f, r, c, win[e*CODE_W +: CODE_W], ex);
        end
      end
    end
  endtask

  task automatic idle();
    logic [9*CODE_W-1:0] keep;
    keep = win;
    in_valid = 1'b0;
    in_code  = '1;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (win_valid !== 1'b0 || win !== keep) begin
      errors++;
      $display("FAIL R5 idle: got v=%0b win=%0h exp v=0 win=%0h", win_valid, win, keep);
    end
  endtask

  task automatic frame(int f, int w, int rows, int limit, bit gaps, string tag);
    int n = 0;
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < w; c++) begin
        if (n < limit) begin
          send(f, r, c, w, tag);
          if (gaps && (c % 2 == 1)) idle();
        end
        n++;
      end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (win_valid !== 1'b0 || win !== '0) begin
      errors++;
      $display("FAIL R1 reset: got v=%0b win=%0h exp v=0 win=0", win_valid, win);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (win_valid !== 1'b0 || win !== '0) begin
      errors++;
      $display("FAIL R1 after reset: got v=%0b win=%0h exp v=0 win=0", win_valid, win);
    end
    frame(0, 5, 5, 1000, 1'b0, "R2");
    frame(1, 3, 4, 1000, 1'b1, "R5");
    frame(2, MAX_W, 3, 1000, 1'b0, "R2");
    frame(3, 7, 3, 10, 1'b0, "R6");
    frame(4, 4, 4, 1000, 1'b0, "R6");
    frame(5, 6, 4, 1000, 1'b1, "R7");
    frame(6, 3, 3, 1000, 1'b0, "R3");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule